// File: doc/BRIEF.md
# Dual Address Generator with Circular and Bit-Reversed Modes

This block produces memory addresses for a processor that has separate data and program memories. It contains two identical generators, one for each memory, so two operand addresses can be formed in the same cycle. Each generator keeps two sets (primary and alternate) of eight register groups. Each group holds an index, a modifier, a buffer length and a buffer base. A mode input per generator picks the active set.

An access request names one index register and one modifier source. The modifier is either a modifier register or an immediate value, and it is signed. Post-modify returns the index and writes back index plus modifier. Pre-modify returns index plus modifier and leaves the index alone. A nonzero length makes the post-modify write-back wrap inside the circular buffer described by base and length. A bit-reverse option mirrors the low address bits of the returned address, for FFT-style access, while the stored index still advances linearly. Registers are loaded through one shared write port. There is no state machine: each generator is register storage, a combinational address path and one output register stage.

Top module: `dual_addr_gen`

## Requirements
- R1: After reset every index, modifier, length and base register in both sets of both generators reads as zero, and `addr_vld` is low.
- R2: A write with `wr_en` high stores `wr_data` into the register chosen by `wr_gen` (0 = data generator, 1 = program generator), `wr_alt` (0 = primary, 1 = alternate), `wr_grp`, and `wr_kind` (0 = index, 1 = modifier, 2 = length, 3 = base).
- R3: Writing a base register also loads the index register of the same group and set with the same value.
- R4: A post-modify access (`acc_pre` = 0) returns the selected index and then updates it to index plus the sign-extended modifier.
- R5: A pre-modify access (`acc_pre` = 1) returns index plus modifier and leaves the index unchanged.
- R6: With `acc_imm_en` high the modifier is `acc_imm`, a two's-complement value, instead of the modifier register chosen by `acc_msel`.
- R7: With a nonzero length L and base B, a post-modify sum at or above B+L is stored as sum minus L.
- R8: With a nonzero length, a post-modify sum below B is stored as sum plus L.
- R9: With length zero, the update is linear and wraps modulo 2^AW.
- R10: With `acc_rev` high the low RB bits (default 4) of the returned address are bit-reversed, while the index update stays linear.
- R11: `mode_alt[g]` selects the alternate register set for generator g. The two sets are independent.
- R12: Both generators accept requests in the same cycle and act only on their own registers.
- R13: When a register write and a post-modify write-back hit the same index register in one cycle, the written value is kept.
- R14: The address for a request appears on `addr_out` with `addr_vld` high in the cycle after the request. Without a request, `addr_vld` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_alt | input | 2 | Per-generator alternate set select |
| wr_en | input | 1 | Register write strobe |
| wr_gen | input | 1 | Target generator of the write |
| wr_alt | input | 1 | Target set of the write |
| wr_kind | input | 2 | Register kind: 0 index, 1 modifier, 2 length, 3 base |
| wr_grp | input | 3 | Register group number |
| wr_data | input | 16 | Write value |
| acc_req | input | 2 | Per-generator access request |
| acc_pre | input | 2 | 1 = pre-modify, 0 = post-modify |
| acc_rev | input | 2 | Bit-reverse the returned address |
| acc_imm_en | input | 2 | Use the immediate as the modifier |
| acc_isel | input | 2x3 | Index register group per generator |
| acc_msel | input | 2x3 | Modifier register group per generator |
| acc_imm | input | 2x16 | Immediate modifier per generator |
| addr_vld | output | 2 | Address valid per generator |
| addr_out | output | 2x16 | Returned address per generator |

## Verification
Two functions can act in the same cycle. A software register write and a post-modify write-back can target the same index register, and both generators can serve requests at once. The bench provokes the first collision by driving an index write to a group together with a post-modify access on that group. It expects the old index on the bus and the written value, not the write-back, on the next access. Simultaneous requests on both generators are judged through per-generator expected-address queues. Each queue must be matched in order, with no cross-talk between the generators.

// File: rtl/dag_pkg.sv
package dag_pkg;
    typedef enum logic [1:0] {
        KIND_IDX  = 2'd0,
        KIND_MOD  = 2'd1,
        KIND_LEN  = 2'd2,
        KIND_BASE = 2'd3
    } reg_kind_e;

    localparam int NSET = 2;
endpackage

// File: rtl/dag_regfile.sv
module dag_regfile
    import dag_pkg::*;
#(
    parameter int AW   = 16,
    parameter int NGRP = 8,
    localparam int GW  = $clog2(NGRP)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          wr_alt,
    input  reg_kind_e     wr_kind,
    input  logic [GW-1:0] wr_grp,
    input  logic [AW-1:0] wr_data,
    input  logic          rd_alt,
    input  logic [GW-1:0] rd_isel,
    input  logic [GW-1:0] rd_msel,
    input  logic          upd_en,
    input  logic [AW-1:0] upd_val,
    output logic [AW-1:0] rd_idx,
    output logic [AW-1:0] rd_mod,
    output logic [AW-1:0] rd_len,
    output logic [AW-1:0] rd_base
);
    logic [NSET-1:0][NGRP-1:0][AW-1:0] idx_q;
    logic [NSET-1:0][NGRP-1:0][AW-1:0] mod_q;
    logic [NSET-1:0][NGRP-1:0][AW-1:0] len_q;
    logic [NSET-1:0][NGRP-1:0][AW-1:0] base_q;

    // The write-back is issued first, so a register write in the same cycle overrides it.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q  <= '0;
            mod_q  <= '0;
            len_q  <= '0;
            base_q <= '0;
        end else begin
            if (upd_en)
                idx_q[rd_alt][rd_isel] <= upd_val;
            if (wr_en) begin
                unique case (wr_kind)
                    KIND_IDX:  idx_q[wr_alt][wr_grp] <= wr_data;
                    KIND_MOD:  mod_q[wr_alt][wr_grp] <= wr_data;
                    KIND_LEN:  len_q[wr_alt][wr_grp] <= wr_data;
                    KIND_BASE: begin
                        base_q[wr_alt][wr_grp] <= wr_data;
                        idx_q[wr_alt][wr_grp]  <= wr_data;
                    end
                endcase
            end
        end
    end

    always_comb begin
        rd_idx  = idx_q[rd_alt][rd_isel];
        rd_mod  = mod_q[rd_alt][rd_msel];
        rd_len  = len_q[rd_alt][rd_isel];
        rd_base = base_q[rd_alt][rd_isel];
    end

    // R3: a base write also lands in the matching index register
    a_r3_base_loads_index: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_kind == KIND_BASE) |=> idx_q[$past(wr_alt)][$past(wr_grp)] == $past(wr_data));

    // R5: with neither write nor write-back, no index register moves
    a_r5_index_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_en && !wr_en) |=> $stable(idx_q));

    // R13: a write to an index register wins over a write-back to it
    a_r13_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_kind == KIND_IDX && upd_en) |=> idx_q[$past(wr_alt)][$past(wr_grp)] == $past(wr_data));
endmodule

// File: rtl/dag_calc.sv
module dag_calc #(
    parameter int AW = 16,
    parameter int RB = 4
) (
    input  logic [AW-1:0] cur_idx,
    input  logic [AW-1:0] modv,
    input  logic [AW-1:0] len,
    input  logic [AW-1:0] base,
    input  logic          pre,
    input  logic          rev,
    output logic [AW-1:0] addr,
    output logic [AW-1:0] nxt_idx
);
    localparam int EW = AW + 2;

    logic signed [EW-1:0] sum_e, base_e, len_e, top_e, wrap_e, mag_e, nxt_e;
    logic [AW-1:0] lin_addr;
    logic [AW-1:0] rev_addr;

    always_comb begin
        sum_e  = $signed({2'b00, cur_idx}) + $signed({{2{modv[AW-1]}}, modv});
        base_e = $signed({2'b00, base});
        len_e  = $signed({2'b00, len});
        top_e  = base_e + len_e;
        if (len == '0)
            wrap_e = sum_e;
        else if (sum_e >= top_e)
            wrap_e = sum_e - len_e;
        else if (sum_e < base_e)
            wrap_e = sum_e + len_e;
        else
            wrap_e = sum_e;
        nxt_idx  = wrap_e[AW-1:0];
        lin_addr = pre ? sum_e[AW-1:0] : cur_idx;
    end

    genvar g;
    generate
        for (g = 0; g < AW; g++) begin : g_rev
            if (g < RB) begin : g_swap
                assign rev_addr[g] = lin_addr[RB-1-g];
            end else begin : g_keep
                assign rev_addr[g] = lin_addr[g];
            end
        end
    endgenerate

    assign addr = rev ? rev_addr : lin_addr;

    // R7/R8: a step no larger than the buffer keeps an in-buffer index in the buffer
    always_comb begin
        mag_e = modv[AW-1] ? -$signed({{2{modv[AW-1]}}, modv}) : $signed({2'b00, modv});
        nxt_e = $signed({2'b00, nxt_idx});
        if (len != '0 && $signed({2'b00, cur_idx}) >= base_e &&
            $signed({2'b00, cur_idx}) < top_e && mag_e <= len_e && top_e < (1 <<< AW)) begin
            a_r7_r8_stay_in_buffer: assert (nxt_e >= base_e && nxt_e < top_e);
        end
    end
endmodule

// File: rtl/dag_unit.sv
module dag_unit
    import dag_pkg::*;
#(
    parameter int AW   = 16,
    parameter int NGRP = 8,
    parameter int RB   = 4,
    localparam int GW  = $clog2(NGRP)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          alt,
    input  logic          wr_en,
    input  logic          wr_alt,
    input  reg_kind_e     wr_kind,
    input  logic [GW-1:0] wr_grp,
    input  logic [AW-1:0] wr_data,
    input  logic          req,
    input  logic          pre,
    input  logic          rev,
    input  logic          imm_en,
    input  logic [GW-1:0] isel,
    input  logic [GW-1:0] msel,
    input  logic [AW-1:0] imm,
    output logic          vld,
    output logic [AW-1:0] addr
);
    logic [AW-1:0] cur_idx, reg_mod, cur_len, cur_base;
    logic [AW-1:0] modv, addr_c, nxt_idx;
    logic          upd_en;
    logic          vld_q;
    logic [AW-1:0] addr_q;

    assign upd_en = req && !pre;
    assign modv   = imm_en ? imm : reg_mod;

    dag_regfile #(.AW(AW), .NGRP(NGRP)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_alt  (wr_alt),
        .wr_kind (wr_kind),
        .wr_grp  (wr_grp),
        .wr_data (wr_data),
        .rd_alt  (alt),
        .rd_isel (isel),
        .rd_msel (msel),
        .upd_en  (upd_en),
        .upd_val (nxt_idx),
        .rd_idx  (cur_idx),
        .rd_mod  (reg_mod),
        .rd_len  (cur_len),
        .rd_base (cur_base)
    );

    dag_calc #(.AW(AW), .RB(RB)) u_calc (
        .cur_idx (cur_idx),
        .modv    (modv),
        .len     (cur_len),
        .base    (cur_base),
        .pre     (pre),
        .rev     (rev),
        .addr    (addr_c),
        .nxt_idx (nxt_idx)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q  <= 1'b0;
            addr_q <= '0;
        end else begin
            vld_q <= req;
            if (req)
                addr_q <= addr_c;
        end
    end

    assign vld  = vld_q;
    assign addr = addr_q;

    // R4: a post-modify access without reversal returns the stored index
    a_r4_post_returns_index: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !pre && !rev) |=> addr_q == $past(cur_idx));

    // R14: the result is flagged one cycle after the request
    a_r14_vld_latency: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> vld);
endmodule

// File: rtl/dual_addr_gen.sv
module dual_addr_gen
    import dag_pkg::*;
#(
    parameter int AW   = 16,
    parameter int NGRP = 8,
    parameter int RB   = 4,
    localparam int GW  = $clog2(NGRP),
    localparam int NGEN = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NGEN-1:0]           mode_alt,
    input  logic                      wr_en,
    input  logic                      wr_gen,
    input  logic                      wr_alt,
    input  logic [1:0]                wr_kind,
    input  logic [GW-1:0]             wr_grp,
    input  logic [AW-1:0]             wr_data,
    input  logic [NGEN-1:0]           acc_req,
    input  logic [NGEN-1:0]           acc_pre,
    input  logic [NGEN-1:0]           acc_rev,
    input  logic [NGEN-1:0]           acc_imm_en,
    input  logic [NGEN-1:0][GW-1:0]   acc_isel,
    input  logic [NGEN-1:0][GW-1:0]   acc_msel,
    input  logic [NGEN-1:0][AW-1:0]   acc_imm,
    output logic [NGEN-1:0]           addr_vld,
    output logic [NGEN-1:0][AW-1:0]   addr_out
);
    reg_kind_e kind;
    assign kind = reg_kind_e'(wr_kind);

    genvar g;
    generate
        for (g = 0; g < NGEN; g++) begin : g_gen
            logic wr_here;
            assign wr_here = wr_en && (wr_gen == g[0]);

            dag_unit #(.AW(AW), .NGRP(NGRP), .RB(RB)) u_unit (
                .clk     (clk),
                .rst_n   (rst_n),
                .alt     (mode_alt[g]),
                .wr_en   (wr_here),
                .wr_alt  (wr_alt),
                .wr_kind (kind),
                .wr_grp  (wr_grp),
                .wr_data (wr_data),
                .req     (acc_req[g]),
                .pre     (acc_pre[g]),
                .rev     (acc_rev[g]),
                .imm_en  (acc_imm_en[g]),
                .isel    (acc_isel[g]),
                .msel    (acc_msel[g]),
                .imm     (acc_imm[g]),
                .vld     (addr_vld[g]),
                .addr    (addr_out[g])
            );
        end
    endgenerate

    // R14: no address is flagged without a request in the previous cycle
    a_r14_no_spurious_vld: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_req == '0) |=> (addr_vld == '0));
endmodule

// File: tb/sim_dual_addr_gen.sv
`timescale 1ns/1ps
module sim_dual_addr_gen;
    typedef struct {
        logic [15:0] a;
        string       tag;
    } exp_t;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [1:0]      mode_alt = '0;
    logic            wr_en = 1'b0, wr_gen = 1'b0, wr_alt = 1'b0;
    logic [1:0]      wr_kind = '0;
    logic [2:0]      wr_grp = '0;
    logic [15:0]     wr_data = '0;
    logic [1:0]      acc_req = '0, acc_pre = '0, acc_rev = '0, acc_imm_en = '0;
    logic [1:0][2:0] acc_isel = '0, acc_msel = '0;
    logic [1:0][15:0] acc_imm = '0;
    logic [1:0]      addr_vld;
    logic [1:0][15:0] addr_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    exp_t q0[$];
    exp_t q1[$];

    dual_addr_gen u0 (
        .clk(clk), .rst_n(rst_n), .mode_alt(mode_alt),
        .wr_en(wr_en), .wr_gen(wr_gen), .wr_alt(wr_alt), .wr_kind(wr_kind),
        .wr_grp(wr_grp), .wr_data(wr_data),
        .acc_req(acc_req), .acc_pre(acc_pre), .acc_rev(acc_rev), .acc_imm_en(acc_imm_en),
        .acc_isel(acc_isel), .acc_msel(acc_msel), .acc_imm(acc_imm),
        .addr_vld(addr_vld), .addr_out(addr_out)
    );

    always #2 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Monitor: pop the expected address for each generator reporting valid
    always @(negedge clk) begin
        if (rst_n && !done) begin
            for (int g = 0; g < 2; g++) begin
                if (addr_vld[g]) begin
                    exp_t e;
                    if (g == 0 && q0.size() > 0) begin
                        e = q0.pop_front();
                        chk(addr_out[g] == e.a, e.tag, addr_out[g], e.a);
                    end else if (g == 1 && q1.size() > 0) begin
                        e = q1.pop_front();
                        chk(addr_out[g] == e.a, e.tag, addr_out[g], e.a);
                    end else begin
                        chk(1'b0, "R14 unexpected valid", addr_out[g], 16'h0);
                    end
                end
            end
        end
    end

    task automatic step();
        @(negedge clk);
        wr_en   = 1'b0;
        acc_req = '0;
    endtask

    task automatic set_wr(input bit gen, input bit alt, input logic [1:0] kind,
                          input logic [2:0] grp, input logic [15:0] data);
        wr_en = 1'b1; wr_gen = gen; wr_alt = alt;
        wr_kind = kind; wr_grp = grp; wr_data = data;
    endtask

    task automatic wr(input bit gen, input bit alt, input logic [1:0] kind,
                      input logic [2:0] grp, input logic [15:0] data);
        set_wr(gen, alt, kind, grp, data);
        step();
    endtask

    // Driver: drive one request and push the expected address to the scoreboard
    task automatic set_acc(input int g, input bit pre, input logic [2:0] isel, input logic [2:0] msel,
                           input bit imm_en, input logic [15:0] imm, input bit rev,
                           input logic [15:0] exp, input string tag);
        exp_t e;
        acc_req[g] = 1'b1; acc_pre[g] = pre; acc_isel[g] = isel; acc_msel[g] = msel;
        acc_imm_en[g] = imm_en; acc_imm[g] = imm; acc_rev[g] = rev;
        e.a = exp; e.tag = tag;
        if (g == 0) q0.push_back(e); else q1.push_back(e);
    endtask

    task automatic acc(input int g, input bit pre, input logic [2:0] isel, input logic [2:0] msel,
                       input bit imm_en, input logic [15:0] imm, input bit rev,
                       input logic [15:0] exp, input string tag);
        set_acc(g, pre, isel, msel, imm_en, imm, rev, exp, tag);
        step();
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(addr_vld == 2'b00, "R1 valid low in reset", {14'h0, addr_vld}, 16'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(addr_vld == 2'b00, "R1 valid low after reset", {14'h0, addr_vld}, 16'h0);

        // R1: zeroed registers give address 0 and no movement
        acc(0, 0, 3, 3, 0, 0, 0, 16'h0000, "R1 reset index");
        acc(0, 0, 3, 3, 0, 0, 0, 16'h0000, "R1 reset modifier");

        // R2/R3/R4/R5
        wr(0, 0, 2'd3, 1, 16'h0100);
        wr(0, 0, 2'd1, 1, 16'h0004);
        acc(0, 0, 1, 1, 0, 0, 0, 16'h0100, "R3 base loads index");
        acc(0, 0, 1, 1, 0, 0, 0, 16'h0104, "R4 post-modify update");
        acc(0, 1, 1, 1, 0, 0, 0, 16'h010C, "R5 pre-modify sum");
        acc(0, 1, 1, 1, 0, 0, 0, 16'h010C, "R5 pre-modify no writeback");
        acc(0, 0, 1, 1, 0, 0, 0, 16'h0108, "R2 modifier register written");

        // R6: immediate -2
        acc(0, 0, 1, 1, 1, 16'hFFFE, 0, 16'h010C, "R6 immediate access");
        acc(0, 0, 1, 1, 0, 0, 0, 16'h010A, "R6 negative immediate applied");

        // R7: circular buffer base 0x200 length 5 step 2
        wr(0, 0, 2'd3, 2, 16'h0200);
        wr(0, 0, 2'd2, 2, 16'h0005);
        wr(0, 0, 2'd1, 2, 16'h0002);
        acc(0, 0, 2, 2, 0, 0, 0, 16'h0200, "R7 ring 0");
        acc(0, 0, 2, 2, 0, 0, 0, 16'h0202, "R7 ring 1");
        acc(0, 0, 2, 2, 0, 0, 0, 16'h0204, "R7 ring 2");
        acc(0, 0, 2, 2, 0, 0, 0, 16'h0201, "R7 upper wrap");
        acc(0, 0, 2, 2, 0, 0, 0, 16'h0203, "R7 after wrap");
        // R8: index now 0x200, step -3 wraps below base
        acc(0, 0, 2, 2, 1, 16'hFFFD, 0, 16'h0200, "R8 ring start");
        acc(0, 0, 2, 2, 0, 0, 0, 16'h0202, "R8 lower wrap");

        // R9: linear wrap across the top of the address space
        wr(0, 0, 2'd3, 4, 16'hFFFE);
        wr(0, 0, 2'd1, 4, 16'h0003);
        acc(0, 0, 4, 4, 0, 0, 0, 16'hFFFE, "R9 linear start");
        acc(0, 0, 4, 4, 0, 0, 0, 16'h0001, "R9 linear modulo wrap");

        // R10: bit reverse of low 4 bits
        wr(0, 0, 2'd3, 5, 16'h0030);
        wr(0, 0, 2'd1, 5, 16'h0001);
        acc(0, 0, 5, 5, 0, 0, 1, 16'h0030, "R10 reverse 0000");
        acc(0, 0, 5, 5, 0, 0, 1, 16'h0038, "R10 reverse 0001");
        acc(0, 0, 5, 5, 0, 0, 1, 16'h0034, "R10 reverse 0010");
        acc(0, 0, 5, 5, 0, 0, 0, 16'h0033, "R10 index stays linear");

        // R11: alternate set
        wr(0, 1, 2'd3, 1, 16'h0500);
        wr(0, 1, 2'd1, 1, 16'h0010);
        mode_alt = 2'b01;
        acc(0, 0, 1, 1, 0, 0, 0, 16'h0500, "R11 alternate index");
        acc(0, 0, 1, 1, 0, 0, 0, 16'h0510, "R11 alternate modifier");
        mode_alt = 2'b00;
        acc(0, 0, 1, 1, 0, 0, 0, 16'h010E, "R11 primary untouched");

        // R12: both generators together
        wr(1, 0, 2'd3, 0, 16'h0700);
        wr(1, 0, 2'd1, 0, 16'h0001);
        wr(0, 0, 2'd3, 0, 16'h0040);
        wr(0, 0, 2'd1, 0, 16'hFFFF);
        set_acc(0, 0, 0, 0, 0, 0, 0, 16'h0040, "R12 data gen first");
        set_acc(1, 0, 0, 0, 0, 0, 0, 16'h0700, "R12 program gen first");
        step();
        set_acc(0, 0, 0, 0, 0, 0, 0, 16'h003F, "R12 data gen second");
        set_acc(1, 0, 0, 0, 0, 0, 0, 16'h0701, "R12 program gen second");
        step();

        // R13: write and write-back on the same index register
        wr(0, 0, 2'd3, 6, 16'h0600);
        wr(0, 0, 2'd1, 6, 16'h0008);
        set_wr(0, 0, 2'd0, 6, 16'h0650);
        set_acc(0, 0, 6, 6, 0, 0, 0, 16'h0600, "R13 old index returned");
        step();
        acc(0, 0, 6, 6, 0, 0, 0, 16'h0650, "R13 write wins");

        // R14: an idle cycle gives no valid
        step();
        chk(addr_vld == 2'b00, "R14 idle no valid", {14'h0, addr_vld}, 16'h0);
        step();
        chk(q0.size() == 0 && q1.size() == 0, "R14 all results delivered",
            16'(q0.size() + q1.size()), 16'h0);

        done = 1'b1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule